// File: doc/BRIEF.md
# LIN Master Frame Controller

This block is the frame engine of a LIN bus master. Software first programs a 6-bit frame identifier, a response length in bytes, a direction bit and a checksum flavour, and writes the response bytes into an eight-entry message buffer. It then pulses a header request. From that point the block needs no further software action for a normal frame. It drives a break field, the 0x55 sync byte and the protected identifier onto the transmit line. When the master publishes the response, it then sends the buffered data bytes followed by the checksum.

Serialisation is done inside the block by a small byte shifter. The shifter advances once per pulse of a baud tick input and compares the bus readback with the driven bit at every tick. Outcomes are reported through four sticky, write-one-to-clear flags with per-flag interrupt enables. Responses longer than the buffer are sent in chunks. After each full buffer the block raises a buffer-empty flag and holds the line recessive until software refills the buffer and acknowledges the refill.

Top module: `lin_master_frame`

## Requirements
- R1: After reset `lin_tx` is high, `flags` is 0, `irq` and `busy` are low, and a frame begins only after a one-cycle pulse on `hdr_req` while `busy` is low.
- R2: Each frame begins with at least 13 low bit times, then a high delimiter, then the sync byte 0x55.
- R3: The third byte sent is the protected identifier. Bits 5:0 hold `cfg_id`. Bit 6 is id0^id1^id2^id4. Bit 7 is the inverse of id1^id3^id4^id5.
- R4: Every byte is sent as one low start bit, eight data bits with the LSB first, and one high stop bit, with one bit per `baud_tick` pulse.
- R5: With `cfg_pub`=0, only the header is sent. Then flag bit 0 (header sent) is set, flag bit 1 stays clear, and `busy` returns low.
- R6: With `cfg_pub`=1, exactly `cfg_len` data bytes follow the header, taken from buffer addresses 0, 1, 2 and so on, and then one checksum byte. Flag bit 1 (response done) is then set.
- R7: With `cfg_enh`=0 the checksum is the inverted end-around-carry 8-bit sum of the data bytes.
- R8: With `cfg_enh`=1 the end-around-carry sum also includes the protected identifier before it is inverted.
- R9: When `cfg_len` exceeds 8, the block sets flag bit 2 (buffer empty) after each group of 8 data bytes. It then keeps `busy` high and `lin_tx` high until `refill_ack` pulses. The pulse clears flag bit 2, and transmission resumes from buffer address 0.
- R10: If `lin_rx` differs from the driven bit at a baud tick, the block sets flag bit 3 (bit error) and abandons the frame. `lin_tx` goes high, `busy` goes low, and flag bit 1 is not set.
- R11: A 1 in `flag_clr` clears that flag bit. When a flag is set in the same cycle as it is cleared, the set wins for that cycle.
- R12: `irq` is high one cycle after any flag bit is set whose `irq_en` bit is 1, and it stays low for flags whose enable is 0.
- R13: A `hdr_req` pulse while a frame is in progress is ignored and does not change the frame being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One pulse per bit time |
| cfg_id | input | 6 | Frame identifier |
| cfg_len | input | LEN_W | Response length in bytes |
| cfg_pub | input | 1 | 1: master publishes the response |
| cfg_enh | input | 1 | 1: enhanced checksum, 0: classic |
| hdr_req | input | 1 | Header request pulse |
| buf_we | input | 1 | Message buffer write enable |
| buf_addr | input | BUF_AW | Message buffer write address |
| buf_wdata | input | 8 | Message buffer write data |
| refill_ack | input | 1 | Software has refilled the buffer |
| flag_clr | input | 4 | Write-one-to-clear for the flags |
| irq_en | input | 4 | Per-flag interrupt enables |
| lin_rx | input | 1 | Bus readback |
| lin_tx | output | 1 | Bus transmit line, high when recessive |
| flags | output | 4 | {bit error, buffer empty, response done, header sent} |
| irq | output | 1 | Interrupt request |
| busy | output | 1 | Frame in progress |

## Verification
The flag register can receive a hardware set and a software clear in the same cycle, and this is the collision the bench targets. The bench holds the response-done clear bit high through a whole published frame, so the clear is active in the exact cycle the checksum completes. It then counts the cycles in which flag bit 1 reads as 1. Exactly one such cycle shows that the set won and that the held clear removed the flag on the next edge. A second overlap, a bit error that arrives after the header-sent flag is already set, is checked by confirming that the header flag remains set while the done flag never appears.

// File: rtl/lin_frame_pkg.sv
package lin_frame_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_BRK, ST_SYNC, ST_PID, ST_RD, ST_GO, ST_DATA, ST_CKS, ST_REFILL
  } fr_state_e;

  localparam int NFLAGS     = 4;
  localparam int FLG_HDR    = 0;
  localparam int FLG_DONE   = 1;
  localparam int FLG_EMPTY  = 2;
  localparam int FLG_BITERR = 3;

  localparam logic [7:0] SYNC_BYTE = 8'h55;

  // identifier with its two parity bits on top
  function automatic logic [7:0] prot_id(input logic [5:0] id);
    logic p0, p1;
    p0 = id[0] ^ id[1] ^ id[2] ^ id[4];
    p1 = ~(id[1] ^ id[3] ^ id[4] ^ id[5]);
    return {p1, p0, id};
  endfunction

  // 8-bit add with the carry folded back in
  function automatic logic [7:0] cks_add(input logic [7:0] a, input logic [7:0] b);
    logic [8:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[7:0] + {7'd0, s[8]};
  endfunction

endpackage

// File: rtl/lin_msg_buf.sv
module lin_msg_buf #(
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);

  logic [7:0] mem [DEPTH];

  // write port and registered read port, block-RAM friendly
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/lin_byte_shifter.sv
module lin_byte_shifter #(
  parameter int BRK_LEN = 13,
  localparam int BMAX = (BRK_LEN > 9) ? BRK_LEN : 9,
  localparam int CW = $clog2(BMAX + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       start,
  input  logic       is_brk,
  input  logic [7:0] data,
  input  logic       rx,
  output logic       tx,
  output logic       busy,
  output logic       done,
  output logic       err
);

  localparam logic [CW-1:0] BRK_LAST  = CW'(BRK_LEN);
  localparam logic [CW-1:0] BYTE_LAST = CW'(9);

  logic          pending, active, brk_q, tx_q, done_q, err_q;
  logic [CW-1:0] cnt;
  logic [9:0]    sh;
  logic [CW-1:0] last;
  logic [CW-1:0] cnt_nx;

  assign last   = brk_q ? BRK_LAST : BYTE_LAST;
  assign cnt_nx = cnt + CW'(1);
  assign busy   = pending | active;
  assign tx     = tx_q;
  assign done   = done_q;
  assign err    = err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= 1'b0;
      active  <= 1'b0;
      brk_q   <= 1'b0;
      tx_q    <= 1'b1;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      cnt     <= '0;
      sh      <= '1;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (start && !busy) begin
        // first bit goes out on the next tick, so every bit is a full period
        pending <= 1'b1;
        brk_q   <= is_brk;
        cnt     <= '0;
        sh      <= {1'b1, data, 1'b0};
      end else if (tick && pending) begin
        pending <= 1'b0;
        active  <= 1'b1;
        tx_q    <= brk_q ? 1'b0 : sh[0];
      end else if (tick && active) begin
        if (rx != tx_q) begin
          err_q  <= 1'b1;
          active <= 1'b0;
          tx_q   <= 1'b1;
        end else if (cnt == last) begin
          done_q <= 1'b1;
          active <= 1'b0;
          tx_q   <= 1'b1;
        end else begin
          cnt  <= cnt_nx;
          sh   <= {1'b1, sh[9:1]};
          tx_q <= brk_q ? (cnt_nx >= BRK_LAST) : sh[1];
        end
      end
    end
  end

  // R10: an abort leaves the shifter idle with the line recessive
  p_err_idle_r10: assert property (@(posedge clk) disable iff (rst)
    err_q |-> (!busy && tx_q));

  // R4: nothing is driven low without a frame in progress
  p_low_needs_active_r4: assert property (@(posedge clk) disable iff (rst)
    !tx_q |-> active);

endmodule

// File: rtl/lin_frame_seq.sv
module lin_frame_seq
  import lin_frame_pkg::*;
#(
  parameter int LEN_W  = 6,
  parameter int BUF_AW = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hdr_req,
  input  logic [5:0]        cfg_id,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic              cfg_pub,
  input  logic              cfg_enh,
  input  logic              refill_ack,
  input  logic [7:0]        buf_rdata,
  output logic [BUF_AW-1:0] buf_raddr,
  input  logic              sh_busy,
  input  logic              sh_done,
  input  logic              sh_err,
  output logic              sh_start,
  output logic              sh_brk,
  output logic [7:0]        sh_data,
  output logic              busy,
  output logic              ev_hdr,
  output logic              ev_done,
  output logic              ev_empty,
  output logic              ev_err
);

  fr_state_e        st, nxt;
  logic [LEN_W-1:0] len_q, cnt, sent;
  logic [7:0]       pid_q, acc;
  logic             pub_q;

  assign sent      = cnt + LEN_W'(1);
  assign buf_raddr = cnt[BUF_AW-1:0];
  assign busy      = (st != ST_IDLE);

  always_comb begin
    nxt      = st;
    sh_start = 1'b0;
    sh_brk   = 1'b0;
    sh_data  = 8'h00;
    ev_hdr   = 1'b0;
    ev_done  = 1'b0;
    ev_empty = 1'b0;
    ev_err   = 1'b0;
    case (st)
      ST_IDLE: if (hdr_req) begin
        sh_start = 1'b1; sh_brk = 1'b1; nxt = ST_BRK;
      end
      ST_BRK: if (sh_done) begin
        sh_start = 1'b1; sh_data = SYNC_BYTE; nxt = ST_SYNC;
      end
      ST_SYNC: if (sh_done) begin
        sh_start = 1'b1; sh_data = pid_q; nxt = ST_PID;
      end
      ST_PID: if (sh_done) begin
        ev_hdr = 1'b1;
        if (!pub_q) nxt = ST_IDLE;
        else if (len_q == '0) begin
          sh_start = 1'b1; sh_data = ~acc; nxt = ST_CKS;
        end else nxt = ST_RD;
      end
      ST_RD: nxt = ST_GO;
      ST_GO: begin
        sh_start = 1'b1; sh_data = buf_rdata; nxt = ST_DATA;
      end
      ST_DATA: if (sh_done) begin
        if (sent == len_q) begin
          sh_start = 1'b1; sh_data = ~acc; nxt = ST_CKS;
        end else if (sent[BUF_AW-1:0] == '0) begin
          ev_empty = 1'b1; nxt = ST_REFILL;
        end else nxt = ST_RD;
      end
      ST_CKS: if (sh_done) begin
        ev_done = 1'b1; nxt = ST_IDLE;
      end
      ST_REFILL: if (refill_ack) nxt = ST_RD;
      default: nxt = ST_IDLE;
    endcase
    if (sh_err) begin
      nxt      = ST_IDLE;
      sh_start = 1'b0;
      ev_hdr   = 1'b0;
      ev_done  = 1'b0;
      ev_empty = 1'b0;
      ev_err   = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ST_IDLE;
      len_q <= '0;
      cnt   <= '0;
      pid_q <= 8'h00;
      acc   <= 8'h00;
      pub_q <= 1'b0;
    end else begin
      st <= nxt;
      if (st == ST_IDLE && hdr_req) begin
        pid_q <= prot_id(cfg_id);
        len_q <= cfg_len;
        pub_q <= cfg_pub;
        acc   <= cfg_enh ? prot_id(cfg_id) : 8'h00;
        cnt   <= '0;
      end
      if (st == ST_GO) acc <= cks_add(acc, buf_rdata);
      if (st == ST_DATA && sh_done && !sh_err) cnt <= sent;
    end
  end

  // R9: while waiting for a refill the shifter sends nothing
  p_refill_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (st == ST_REFILL) |-> !sh_busy);

  // R6: data bytes are only fetched while publishing
  p_data_pub_only_r6: assert property (@(posedge clk) disable iff (rst)
    (st == ST_GO) |-> pub_q);

endmodule

// File: rtl/lin_master_frame.sv
module lin_master_frame
  import lin_frame_pkg::*;
#(
  parameter int LEN_W     = 6,
  parameter int BUF_DEPTH = 8,
  parameter int BRK_LEN   = 13,
  localparam int BUF_AW   = $clog2(BUF_DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              baud_tick,
  input  logic [5:0]        cfg_id,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic              cfg_pub,
  input  logic              cfg_enh,
  input  logic              hdr_req,
  input  logic              buf_we,
  input  logic [BUF_AW-1:0] buf_addr,
  input  logic [7:0]        buf_wdata,
  input  logic              refill_ack,
  input  logic [3:0]        flag_clr,
  input  logic [3:0]        irq_en,
  input  logic              lin_rx,
  output logic              lin_tx,
  output logic [3:0]        flags,
  output logic              irq,
  output logic              busy
);

  logic [BUF_AW-1:0] raddr;
  logic [7:0]        rdata, sh_data;
  logic              sh_busy, sh_done, sh_err, sh_start, sh_brk;
  logic              ev_hdr, ev_done, ev_empty, ev_err;
  logic [NFLAGS-1:0] flg_q, flg_set, flg_clr;

  lin_msg_buf #(.DEPTH(BUF_DEPTH)) u_buf (
    .clk(clk), .we(buf_we), .waddr(buf_addr), .wdata(buf_wdata),
    .raddr(raddr), .rdata(rdata)
  );

  lin_byte_shifter #(.BRK_LEN(BRK_LEN)) u_shift (
    .clk(clk), .rst(rst), .tick(baud_tick), .start(sh_start), .is_brk(sh_brk),
    .data(sh_data), .rx(lin_rx), .tx(lin_tx), .busy(sh_busy),
    .done(sh_done), .err(sh_err)
  );

  lin_frame_seq #(.LEN_W(LEN_W), .BUF_AW(BUF_AW)) u_seq (
    .clk(clk), .rst(rst), .hdr_req(hdr_req), .cfg_id(cfg_id), .cfg_len(cfg_len),
    .cfg_pub(cfg_pub), .cfg_enh(cfg_enh), .refill_ack(refill_ack),
    .buf_rdata(rdata), .buf_raddr(raddr), .sh_busy(sh_busy), .sh_done(sh_done),
    .sh_err(sh_err), .sh_start(sh_start), .sh_brk(sh_brk), .sh_data(sh_data),
    .busy(busy), .ev_hdr(ev_hdr), .ev_done(ev_done), .ev_empty(ev_empty),
    .ev_err(ev_err)
  );

  always_comb begin
    flg_set = '0;
    flg_set[FLG_HDR]    = ev_hdr;
    flg_set[FLG_DONE]   = ev_done;
    flg_set[FLG_EMPTY]  = ev_empty;
    flg_set[FLG_BITERR] = ev_err;
    flg_clr = flag_clr;
    if (refill_ack) flg_clr[FLG_EMPTY] = 1'b1;
  end

  // sticky flags: a set in the same cycle beats the clear
  always_ff @(posedge clk) begin
    if (rst) begin
      flg_q <= '0;
      irq   <= 1'b0;
    end else begin
      flg_q <= (flg_q & ~flg_clr) | flg_set;
      irq   <= |(flg_q & irq_en);
    end
  end

  assign flags = flg_q;

  // R1: line is recessive whenever no frame runs
  p_idle_recessive_r1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> lin_tx);

  // R1: a frame only begins after a header request
  p_start_on_req_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(hdr_req));

  // R11: a completion event is always visible in the next cycle
  p_done_sets_r11: assert property (@(posedge clk) disable iff (rst)
    ev_done |=> flags[FLG_DONE]);

  // R12: no interrupt from a fully masked flag set
  p_irq_masked_r12: assert property (@(posedge clk) disable iff (rst)
    ($past(irq_en) == 4'h0) |-> !irq);

  // R10: a bit error ends the frame at once
  p_err_aborts_r10: assert property (@(posedge clk) disable iff (rst)
    ev_err |=> (!busy && !flags[FLG_DONE] || $past(flags[FLG_DONE])));

endmodule

// File: tb/lin_master_frame_tb.sv
module lin_master_frame_tb;

  localparam int LEN_W = 6;
  localparam int TICK_DIV = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       baud_tick = 1'b0;
  logic [5:0] cfg_id = '0;
  logic [LEN_W-1:0] cfg_len = '0;
  logic       cfg_pub = 1'b0, cfg_enh = 1'b0, hdr_req = 1'b0;
  logic       buf_we = 1'b0;
  logic [2:0] buf_addr = '0;
  logic [7:0] buf_wdata = '0;
  logic       refill_ack = 1'b0;
  logic [3:0] flag_clr = '0, irq_en = '0;
  logic       inj = 1'b0;
  logic       lin_rx, lin_tx, irq, busy;
  logic [3:0] flags;

  int vectors = 0, errors = 0, cycles = 0, tdiv = 0;
  logic bitlog [0:2047];
  int   nb = 0;
  int   rxb [0:63];
  int   nbytes, brk;
  int   expd [0:63];

  assign lin_rx = lin_tx ^ inj;

  always #4 clk = ~clk;

  lin_master_frame #(.LEN_W(LEN_W)) u_dut (
    .clk(clk), .rst(rst), .baud_tick(baud_tick), .cfg_id(cfg_id),
    .cfg_len(cfg_len), .cfg_pub(cfg_pub), .cfg_enh(cfg_enh), .hdr_req(hdr_req),
    .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
    .refill_ack(refill_ack), .flag_clr(flag_clr), .irq_en(irq_en),
    .lin_rx(lin_rx), .lin_tx(lin_tx), .flags(flags), .irq(irq), .busy(busy)
  );

  always @(posedge clk) begin
    tdiv <= (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
    baud_tick <= (tdiv == TICK_DIV - 1);
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  always @(negedge clk) if (baud_tick && nb < 2048) begin
    bitlog[nb] = lin_tx;
    nb = nb + 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    vectors = vectors + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1;
    end
  endtask

  function automatic int pid_of(input int id);
    int b [0:5];
    for (int k = 0; k < 6; k++) b[k] = (id >> k) & 1;
    return id | ((b[0] ^ b[1] ^ b[2] ^ b[4]) << 6) | ((1 - (b[1] ^ b[3] ^ b[4] ^ b[5])) << 7);
  endfunction

  function automatic int sum_fold(input int s, input int v);
    int t;
    t = s + v;
    if (t > 255) t = t - 255;
    return t;
  endfunction

  task automatic wr(input int a, input int d);
    buf_we = 1'b1; buf_addr = a[2:0]; buf_wdata = d[7:0];
    step(1);
    buf_we = 1'b0;
  endtask

  task automatic launch(input int id, input int len, input bit pub, input bit enh);
    cfg_id = id[5:0]; cfg_len = len[LEN_W-1:0]; cfg_pub = pub; cfg_enh = enh;
    nb = 0;
    hdr_req = 1'b1; step(1); hdr_req = 1'b0;
  endtask

  task automatic wait_idle();
    step(1);
    while (busy) step(1);
    step(TICK_DIV * 3);
  endtask

  task automatic decode();
    int i;
    i = 0; brk = 0; nbytes = 0;
    while (i < nb && bitlog[i] == 1'b1) i++;
    while (i < nb && bitlog[i] == 1'b0) begin brk++; i++; end
    while (i < nb) begin
      while (i < nb && bitlog[i] == 1'b1) i++;
      if (i + 10 > nb) break;
      rxb[nbytes] = 0;
      for (int k = 0; k < 8; k++) rxb[nbytes] |= int'(bitlog[i + 1 + k]) << k;
      if (bitlog[i + 9] != 1'b1) rxb[nbytes] = -1;
      nbytes++;
      i += 10;
    end
  endtask

  task automatic clear_all();
    flag_clr = 4'hF; step(1); flag_clr = 4'h0; step(1);
  endtask

  task automatic t_reset();
    chk("R1 tx idle", lin_tx, 1);
    chk("R1 flags", flags, 0);
    chk("R1 irq", irq, 0);
    chk("R1 busy", busy, 0);
    step(20);
    chk("R1 no frame without request", busy, 0);
  endtask

  task automatic t_subscriber();
    launch(6'h3C, 4, 1'b0, 1'b0);
    step(30);
    cfg_id = 6'h01;
    hdr_req = 1'b1; step(1); hdr_req = 1'b0; // R13 ignored
    wait_idle();
    decode();
    chk("R2 break length >= 13", brk >= 13, 1);
    chk("R2 sync byte", rxb[0], 8'h55);
    chk("R3 protected id", rxb[1], pid_of(6'h3C));
    chk("R5 header only", nbytes, 2);
    chk("R5 header flag", flags[0], 1);
    chk("R5 no done flag", flags[1], 0);
    step(40);
    chk("R13 no second frame", busy, 0);
  endtask

  task automatic t_publish(input int id, input int len, input bit enh, input int seed);
    int s;
    clear_all();
    for (int k = 0; k < len; k++) wr(k, (seed + 37 * k) & 8'hFF);
    launch(id, len, 1'b1, enh);
    wait_idle();
    decode();
    s = enh ? pid_of(id) : 0;
    for (int k = 0; k < len; k++) s = sum_fold(s, (seed + 37 * k) & 8'hFF);
    chk("R4 frame byte count", nbytes, len + 3);
    chk("R3 protected id", rxb[1], pid_of(id));
    for (int k = 0; k < len; k++) chk("R6 data byte", rxb[2 + k], (seed + 37 * k) & 8'hFF);
    chk(enh ? "R8 enhanced checksum" : "R7 classic checksum", rxb[len + 2], (~s) & 8'hFF);
    chk("R6 done flag", flags[1], 1);
  endtask

  task automatic t_extended();
    int s;
    clear_all();
    for (int k = 0; k < 8; k++) begin expd[k] = 8'hA0 + k; wr(k, expd[k]); end
    for (int k = 0; k < 3; k++) expd[8 + k] = 8'hB5 + 3 * k;
    launch(6'h12, 11, 1'b1, 1'b0);
    step(1);
    while (!flags[2]) step(1);
    chk("R9 buffer empty flag", flags[2], 1);
    for (int k = 0; k < 24; k++) begin
      if (lin_tx !== 1'b1 || busy !== 1'b1) begin
        chk("R9 hold line while waiting", {busy, lin_tx}, 2'b11);
        break;
      end
      step(1);
    end
    for (int k = 0; k < 3; k++) wr(k, expd[8 + k]);
    refill_ack = 1'b1; step(1); refill_ack = 1'b0;
    chk("R9 refill clears empty flag", flags[2], 0);
    wait_idle();
    decode();
    s = 0;
    for (int k = 0; k < 11; k++) s = sum_fold(s, expd[k]);
    chk("R9 extended byte count", nbytes, 14);
    for (int k = 0; k < 11; k++) chk("R9 extended data", rxb[2 + k], expd[k]);
    chk("R9 extended checksum", rxb[13], (~s) & 8'hFF);
    chk("R9 done after refill", flags[1], 1);
  endtask

  task automatic t_biterr();
    clear_all();
    for (int k = 0; k < 4; k++) wr(k, 8'h00);
    launch(6'h2A, 4, 1'b1, 1'b1);
    while (!flags[0]) step(1);
    step(TICK_DIV * 6);
    inj = 1'b1;
    while (busy) step(1);
    inj = 1'b0;
    step(2);
    chk("R10 bit error flag", flags[3], 1);
    chk("R10 no done flag", flags[1], 0);
    chk("R10 header flag kept", flags[0], 1);
    chk("R10 line recessive", lin_tx, 1);
    step(TICK_DIV * 40);
    chk("R10 frame abandoned", busy, 0);
  endtask

  task automatic t_irq();
    clear_all();
    irq_en = 4'h0;
    wr(0, 8'h5A);
    launch(6'h05, 1, 1'b1, 1'b0);
    wait_idle();
    chk("R12 masked flags give no irq", irq, 0);
    irq_en = 4'b0010; step(2);
    chk("R12 enabled flag raises irq", irq, 1);
    flag_clr = 4'b0010; step(1); flag_clr = 4'h0; step(2);
    chk("R11 write one clears", flags, 4'b0001);
    chk("R12 irq drops with flag", irq, 0);
    irq_en = 4'h0;
  endtask

  task automatic t_collide();
    int seen;
    clear_all();
    wr(0, 8'h11);
    flag_clr = 4'b0010;
    launch(6'h07, 1, 1'b1, 1'b1);
    seen = 0;
    step(1);
    while (busy) begin
      if (flags[1]) seen++;
      step(1);
    end
    for (int k = 0; k < 5; k++) begin
      if (flags[1]) seen++;
      step(1);
    end
    flag_clr = 4'h0;
    chk("R11 set wins over held clear for one cycle", seen, 1);
  endtask

  initial begin
    step(5);
    rst = 1'b0;
    step(2);
    t_reset();
    t_subscriber();
    t_publish(6'h3C, 3, 1'b0, 8'h4B);
    t_publish(6'h21, 8, 1'b1, 8'hE1);
    t_extended();
    t_biterr();
    t_irq();
    t_collide();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule